// File: doc/BRIEF.md
# Instruction Immediate Builder with Branch Operand Comparator

This block serves the decode and branch path of a small 32-bit load/store core. From a fetched instruction word and a two-bit format select it forms the 32-bit sign-extended immediate for the arithmetic/load layout (I), the store layout (S) or the conditional-branch layout (B). Alongside it, a comparator takes the two branch operands and reports whether they are equal and whether the first is below the second. The "below" test is either signed or unsigned, depending on a mode input. A branch unit takes "greater or equal" as the inverse of the less-than flag. The block does not make the branch decision itself.

The immediate bits come from fixed wires wherever the formats agree. The five low bits use one two-way selection between their two possible instruction positions. Bit 11 uses a one-bit selection, and bit 0 is forced to zero in branch format. For timing in an FPGA flow, all outputs are captured in one output register stage. Each result therefore appears on the clock edge after its inputs are presented.

Top module: `immcmp_top`

## Requirements
- R1: With format select 0 (I), imm[11:0] equals instr[31:20].
- R2: With format select 1 (S), imm[11:5] equals instr[31:25] and imm[4:0] equals instr[11:7].
- R3: With format select 2 (B), imm[0] is 0, imm[4:1] equals instr[11:8], imm[10:5] equals instr[30:25] and imm[11] equals instr[7].
- R4: For format selects 0, 1 and 2, every immediate bit above the format's field equals instr[31]. This covers imm[31:12], and bit 12 in B format is also instr[31].
- R5: Format select 3 yields an all-zero immediate.
- R6: The equal flag is 1 exactly when the two operands are bit-for-bit identical. When it is 1, the less-than flag is 0.
- R7: With the unsigned mode input at 0, the less-than flag is 1 exactly when operand A is below operand B as two's-complement numbers.
- R8: With the unsigned mode input at 1, the less-than flag is 1 exactly when operand A is below operand B as unsigned numbers.
- R9: Every output is registered. It reflects the inputs sampled at the previous rising clock edge. While the synchronous active-high reset is sampled high, the immediate becomes zero and both flags become 0.
- R10: A B-format immediate spans byte offsets -4096 (0xFFFFF000) to +4094 (0x00000FFE) in steps of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word |
| fmt_sel | input | 2 | Immediate format: 0 = I, 1 = S, 2 = B, 3 = none |
| opa | input | OP_W (32) | Comparator operand A |
| opb | input | OP_W (32) | Comparator operand B |
| unsigned_cmp | input | 1 | 1 = unsigned less-than, 0 = signed |
| imm_q | output | 32 | Registered immediate |
| eq_q | output | 1 | Registered equal flag |
| lt_q | output | 1 | Registered less-than flag |

## Verification
The bound checks compare each registered output with the input values of the preceding cycle. They therefore assume that every input is stable and known at each sampling edge, and they stay silent for the first cycle after reset releases. The stimulus changes all inputs only on falling edges and holds them at defined values from time zero, including throughout reset. The format select is always a known code, and code 3 is applied on purpose to exercise the zero case.

// File: rtl/immcmp_pkg.sv
package immcmp_pkg;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 32;

  typedef enum logic [1:0] {
    FMT_I    = 2'd0,
    FMT_S    = 2'd1,
    FMT_B    = 2'd2,
    FMT_NONE = 2'd3
  } fmt_e;
endpackage

// File: rtl/immcmp_immgen.sv
module immcmp_immgen
  import immcmp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  fmt_e               fmt,
  output logic [IMM_W-1:0]   imm
);
  localparam int EXT_W = IMM_W - 12;

  logic       low_from_rd;
  logic [4:0] low_field;
  logic       bit11;
  logic       valid;

  // The five low bits sit either in the rs2 position or the rd position.
  assign low_from_rd = (fmt == FMT_S) || (fmt == FMT_B);
  assign valid       = (fmt != FMT_NONE);

  always_comb begin
    low_field = low_from_rd ? instr[11:7] : instr[24:20];
    // Branch offsets are always even.
    if (fmt == FMT_B) low_field[0] = 1'b0;
  end

  // Only bit 11 moves between S and B layouts.
  assign bit11 = (fmt == FMT_B) ? instr[7] : instr[31];

  always_comb begin
    if (valid)
      imm = {{EXT_W{instr[31]}}, bit11, instr[30:25], low_field};
    else
      imm = '0;
  end
endmodule

// File: rtl/immcmp_compare.sv
module immcmp_compare #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  input  logic            is_unsigned,
  output logic            eq,
  output logic            lt
);
  localparam int EXT_W = OP_W + 1;

  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] b_ext;
  logic [EXT_W-1:0] diff;

  // Extending by one bit puts both modes in a common signed range.
  assign a_ext = {is_unsigned ? 1'b0 : a[OP_W-1], a};
  assign b_ext = {is_unsigned ? 1'b0 : b[OP_W-1], b};
  assign diff  = a_ext - b_ext;

  assign eq = ~|(a ^ b);
  assign lt = diff[EXT_W-1];
endmodule

// File: rtl/immcmp_outreg.sv
module immcmp_outreg #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/immcmp_top.sv
module immcmp_top
  import immcmp_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [1:0]         fmt_sel,
  input  logic [OP_W-1:0]    opa,
  input  logic [OP_W-1:0]    opb,
  input  logic               unsigned_cmp,
  output logic [IMM_W-1:0]   imm_q,
  output logic               eq_q,
  output logic               lt_q
);
  localparam int STAGE_W = IMM_W + 2;

  fmt_e             fmt;
  logic [IMM_W-1:0] imm_d;
  logic             eq_d;
  logic             lt_d;
  logic [STAGE_W-1:0] stage_q;

  assign fmt = fmt_e'(fmt_sel);

  immcmp_immgen u_immgen (
    .instr (instr),
    .fmt   (fmt),
    .imm   (imm_d)
  );

  immcmp_compare #(.OP_W(OP_W)) u_cmp (
    .a           (opa),
    .b           (opb),
    .is_unsigned (unsigned_cmp),
    .eq          (eq_d),
    .lt          (lt_d)
  );

  immcmp_outreg #(.W(STAGE_W)) u_outreg (
    .clk (clk),
    .rst (rst),
    .d   ({imm_d, eq_d, lt_d}),
    .q   (stage_q)
  );

  assign imm_q = stage_q[STAGE_W-1:2];
  assign eq_q  = stage_q[1];
  assign lt_q  = stage_q[0];
endmodule

// File: rtl/immcmp_chk.sv
module immcmp_chk #(
  parameter int OP_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     instr,
  input logic [1:0]      fmt_sel,
  input logic [OP_W-1:0] opa,
  input logic [OP_W-1:0] opb,
  input logic            unsigned_cmp,
  input logic [31:0]     imm_q,
  input logic            eq_q,
  input logic            lt_q
);
  p_i_field_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_sel) == 2'd0) |-> imm_q[11:0] == $past(instr[31:20]));

  p_s_field_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_sel) == 2'd1) |->
      (imm_q[11:5] == $past(instr[31:25]) && imm_q[4:0] == $past(instr[11:7])));

  p_b_field_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_sel) == 2'd2) |->
      (imm_q[0] == 1'b0 && imm_q[4:1] == $past(instr[11:8]) &&
       imm_q[10:5] == $past(instr[30:25]) && imm_q[11] == $past(instr[7])));

  p_sign_ext_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_sel) != 2'd3) |-> imm_q[31:12] == {20{$past(instr[31])}});

  p_none_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_sel) == 2'd3) |-> imm_q == 32'd0);

  p_eq_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> eq_q == ($past(opa) == $past(opb)));

  p_eq_not_lt_r6: assert property (@(posedge clk) disable iff (rst)
    eq_q |-> !lt_q);

  p_signed_lt_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(unsigned_cmp)) |-> lt_q == ($signed($past(opa)) < $signed($past(opb))));

  p_unsigned_lt_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(unsigned_cmp)) |-> lt_q == ($past(opa) < $past(opb)));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imm_q == 32'd0 && !eq_q && !lt_q));
endmodule

bind immcmp_top immcmp_chk #(.OP_W(OP_W)) u_immcmp_chk (
  .clk          (clk),
  .rst          (rst),
  .instr        (instr),
  .fmt_sel      (fmt_sel),
  .opa          (opa),
  .opb          (opb),
  .unsigned_cmp (unsigned_cmp),
  .imm_q        (imm_q),
  .eq_q         (eq_q),
  .lt_q         (lt_q)
);

// File: tb/test_immcmp_top.sv
module test_immcmp_top;
  localparam int OP_W   = 32;
  localparam int NVEC   = 10;
  localparam int VEC_W  = 32 + 2 + OP_W + OP_W + 1 + 1 + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [31:0]     instr = '0;
  logic [1:0]      fmt_sel = '0;
  logic [OP_W-1:0] opa = '0;
  logic [OP_W-1:0] opb = '0;
  logic            unsigned_cmp = 1'b0;
  logic [31:0]     imm_q;
  logic            eq_q;
  logic            lt_q;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  immcmp_top #(.OP_W(OP_W)) i_immcmp_top (
    .clk (clk), .rst (rst), .instr (instr), .fmt_sel (fmt_sel),
    .opa (opa), .opb (opb), .unsigned_cmp (unsigned_cmp),
    .imm_q (imm_q), .eq_q (eq_q), .lt_q (lt_q)
  );

  // Row: instr, fmt, a, b, unsigned, expected eq, expected lt.
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {32'hFCE08793, 2'd0, 32'h00000005, 32'h00000005, 1'b0, 1'b1, 1'b0},
    {32'h00812703, 2'd0, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 1'b1},
    {32'h00E12423, 2'd1, 32'hFFFFFFFF, 32'h00000001, 1'b1, 1'b0, 1'b0},
    {32'hFE112E23, 2'd1, 32'h80000000, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b1},
    {32'h00208463, 2'd2, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b0, 1'b0},
    {32'hFE209EE3, 2'd2, 32'h7FFFFFFF, 32'h80000000, 1'b1, 1'b0, 1'b1},
    {32'h7FF00013, 2'd0, 32'h00000003, 32'h00000007, 1'b1, 1'b0, 1'b1},
    {32'hA5A5A5A5, 2'd3, 32'h80000000, 32'h80000000, 1'b1, 1'b1, 1'b0},
    {32'h5A5A5AA3, 2'd1, 32'h00000007, 32'h00000003, 1'b0, 1'b0, 1'b0},
    {32'hC0000F63, 2'd2, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b1}
  };

  // Reference immediate assembled from the format definitions.
  function automatic logic [31:0] ref_imm(input logic [31:0] i, input logic [1:0] f);
    case (f)
      2'd0:    return {{20{i[31]}}, i[31:20]};
      2'd1:    return {{20{i[31]}}, i[31:25], i[11:7]};
      2'd2:    return {{19{i[31]}}, i[31], i[7], i[30:25], i[11:8], 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [1:0] f,
                       input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                       input logic u);
    @(negedge clk);
    instr = i; fmt_sel = f; opa = a; opb = b; unsigned_cmp = u;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check32("R9 reset imm", imm_q, 32'd0);
    check32("R9 reset flags", {30'd0, eq_q, lt_q}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      logic [31:0] vi;
      logic [1:0]  vf;
      logic [OP_W-1:0] va, vb;
      logic vu, ve, vl;
      {vi, vf, va, vb, vu, ve, vl} = VECS[k];
      apply(vi, vf, va, vb, vu);
      // R1 R2 R3 R4 R5 immediate per format
      check32($sformatf("R1/R2/R3/R4/R5 imm row %0d", k), imm_q, ref_imm(vi, vf));
      // R6 equality
      check32($sformatf("R6 eq row %0d", k), {31'd0, eq_q}, {31'd0, ve});
      // R7 signed, R8 unsigned less-than
      check32($sformatf("%s lt row %0d", vu ? "R8" : "R7", k), {31'd0, lt_q}, {31'd0, vl});
    end

    // R10: most negative branch offset
    apply(32'h80000063, 2'd2, 32'd1, 32'd1, 1'b0);
    check32("R10 min offset", imm_q, 32'hFFFFF000);
    // R10: most positive branch offset
    apply(32'h7E000FE3, 2'd2, 32'd1, 32'd2, 1'b0);
    check32("R10 max offset", imm_q, 32'h00000FFE);
    // R3: bit 0 forced low even with instr[8:7] set
    apply(32'h00000180, 2'd2, 32'd0, 32'd0, 1'b0);
    check32("R3 bit0 low bit11 from instr7", imm_q, 32'h00000802);
    // R5: unused code with every bit set
    apply(32'hFFFFFFFF, 2'd3, 32'd0, 32'd0, 1'b1);
    check32("R5 unused code", imm_q, 32'd0);
    // R4: I with sign set
    apply(32'h80000000, 2'd0, 32'd0, 32'd0, 1'b1);
    check32("R4 sign fill", imm_q, 32'hFFFFF800);

    // R9: one-cycle latency, output holds old value before the edge
    @(negedge clk);
    instr = 32'h00100013; fmt_sel = 2'd0; opa = 32'd9; opb = 32'd9;
    @(posedge clk);
    #2;
    check32("R9 latency", imm_q, 32'h00000001);
    check32("R6 latency eq", {31'd0, eq_q}, 32'd1);

    // R9: mid-run reset clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check32("R9 mid-run reset", {imm_q[31:2], eq_q | imm_q[1], lt_q | imm_q[0]}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check32("R9 after release", imm_q, 32'h00000001);

    finish_run();
  end
endmodule